// File: doc/BRIEF.md
# Microprogram Sequencer Control

This block steps a dual-issue vector coprocessor through its local microcode store. A program is a run of 64-bit bundles, one bundle per cycle. The sequencer owns the byte fetch address. Each cycle it looks at the control bits carried in the upper word of the bundle that the store returns for that address. From those bits it retires an end-of-program request and applies taken branches, each after one delay-slot bundle. It also raises host-visible status and an interrupt pulse for debug-break and trace-stop markers, but only when the host has enabled them.

The store is read combinationally at `fetch_addr_o`. The integration feeds bits 30..27 of the returned upper word into `ctl_bits_i`. The lower-word decoder reports a taken branch on `br_take_i` together with its byte target. A host starts a program with a one-cycle `start_i` and waits for `done_o`. Parameter `VARIANT` picks between two unit flavours: flavour 0 keeps a sticky marker bit, and flavour 1 halts as soon as a break or trace stop fires.

The controller has two states. In `ST_IDLE`, `start_i` takes the transition "launch" to `ST_RUN`. In `ST_RUN`, `start_i` takes "restart" back into `ST_RUN`, an expiring end countdown takes "retire" to `ST_IDLE`, and otherwise the controller takes "step", staying in `ST_RUN` and advancing.

Top module: `mseq_ctrl`

## Requirements
- R1: After reset `fetch_addr_o` is 0, and `running_o`, `done_o`, `irq_o` and the three status outputs are all 0.
- R2: When `start_i` is high at a clock edge, `fetch_addr_o` takes `start_addr_i`, `running_o` becomes 1 and the three sticky status outputs clear, whatever the current state.
- R3: While running, with no branch outstanding, `fetch_addr_o` advances by 8 at each clock edge.
- R4: A bundle with `ctl_bits_i[3]` set (end) lets exactly one further bundle execute. On the edge that retires that following bundle, `running_o` falls, `fetch_addr_o` moves past it, and `done_o` is high for one cycle.
- R5: While not running and without `start_i`, `fetch_addr_o` holds, `ctl_bits_i` and `br_take_i` have no effect, and `irq_o` stays 0.
- R6: A running bundle with `ctl_bits_i[1]` set (break) while `brk_en_i` is 1 sets `stat_brk_o` until the next start, and it raises `irq_o` for the cycle that follows that bundle. With `brk_en_i` at 0 the bit does nothing.
- R7: `ctl_bits_i[0]` (trace stop) behaves as in R6, but it is gated by `trc_en_i` and it sets `stat_trc_o`.
- R8: With `VARIANT` = 1, a break or trace stop that fires ends the program after the current bundle. `running_o` falls and `done_o` pulses on the same edge as the `irq_o` rise.
- R9: With `VARIANT` = 0, a running bundle with `ctl_bits_i[2]` set (marker) sets `stat_mark_o` until the next start. With `VARIANT` = 1 the bit is ignored and `stat_mark_o` stays 0.
- R10: A taken branch on the bundle at address A fetches A+8 next (the delay slot), then the branch target.
- R11: A branch taken in the delay slot of another branch is held as pending. When the first branch redirects to its target T1, the pending branch starts a new countdown. T1 and T1+8 execute, and then fetch continues at the pending target.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | One-cycle program launch |
| start_addr_i | input | ADDR_W | Byte address of the first bundle |
| ctl_bits_i | input | 4 | Upper-word bits 30..27 of the fetched bundle: [3] end, [2] marker, [1] break, [0] trace stop |
| br_take_i | input | 1 | The fetched bundle takes a branch |
| br_target_i | input | ADDR_W | Byte target of that branch |
| brk_en_i | input | 1 | Host enable for break |
| trc_en_i | input | 1 | Host enable for trace stop |
| fetch_addr_o | output | ADDR_W | Byte address of the bundle being executed |
| running_o | output | 1 | Program is running |
| done_o | output | 1 | One-cycle pulse when a program retires |
| stat_brk_o | output | 1 | Sticky break status |
| stat_trc_o | output | 1 | Sticky trace-stop status |
| stat_mark_o | output | 1 | Sticky marker status (VARIANT 0) |
| irq_o | output | 1 | One-cycle interrupt pulse |

## Verification
The assertions take for granted three things about the inputs. `ctl_bits_i` and `br_take_i` describe the bundle at the current `fetch_addr_o` and settle before the edge. Start addresses and branch targets are multiples of 8. `br_take_i` is a plain level, and nothing about it is assumed while the sequencer is idle. The bench meets these by deriving the control bits, branch strobe and target from a bundle table indexed by each instance's own fetch address. It draws only 8-aligned addresses and changes `start_i` and the enables only between edges. Random programs mix end, break, trace, marker and branch bits at low density, so that back-to-back branches, a stop inside a delay slot and mid-run restarts all occur.

// File: rtl/mseq_pkg.sv
package mseq_pkg;

    // positions inside the 4-bit control field (upper-word bits 30..27)
    localparam int CB_END  = 3;
    localparam int CB_MARK = 2;
    localparam int CB_BRK  = 1;
    localparam int CB_TRC  = 0;
    localparam int CB_W    = 4;

    // bundle size in bytes
    localparam int BUNDLE_BYTES = 8;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } seq_state_e;

    typedef struct packed {
        logic end_hit;
        logic brk_hit;
        logic trc_hit;
        logic mark_hit;
        logic stop_now;
    } flag_hits_t;

endpackage

// File: rtl/mseq_flag_dec.sv
module mseq_flag_dec
    import mseq_pkg::*;
#(
    parameter int VARIANT = 0
) (
    input  logic            active,
    input  logic [CB_W-1:0] ctl_bits,
    input  logic            brk_en,
    input  logic            trc_en,
    output flag_hits_t      hits
);
    localparam logic MARK_KEEP = (VARIANT == 0);
    localparam logic STOP_HALT = (VARIANT != 0);

    logic brk_f;
    logic trc_f;

    always_comb begin
        brk_f          = active & ctl_bits[CB_BRK] & brk_en;
        trc_f          = active & ctl_bits[CB_TRC] & trc_en;
        hits.end_hit   = active & ctl_bits[CB_END];
        hits.brk_hit   = brk_f;
        hits.trc_hit   = trc_f;
        hits.mark_hit  = active & ctl_bits[CB_MARK] & MARK_KEEP;
        hits.stop_now  = (brk_f | trc_f) & STOP_HALT;
    end

endmodule

// File: rtl/mseq_end_timer.sv
module mseq_end_timer (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic step,
    input  logic load_two,
    input  logic force_one,
    output logic expire
);
    logic [1:0] cnt_q;
    logic [1:0] cnt_eff;

    always_comb begin
        if (force_one)     cnt_eff = 2'd1;
        else if (load_two) cnt_eff = 2'd2;
        else               cnt_eff = cnt_q;
        expire = step && (cnt_eff == 2'd1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= 2'd0;
        end else if (clear || expire) begin
            cnt_q <= 2'd0;
        end else if (step) begin
            cnt_q <= (cnt_eff == 2'd0) ? 2'd0 : cnt_eff - 2'd1;
        end
    end

endmodule

// File: rtl/mseq_branch.sv
module mseq_branch #(
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              step,
    input  logic              br_take,
    input  logic [ADDR_W-1:0] br_target,
    input  logic [ADDR_W-1:0] pc_inc,
    output logic [ADDR_W-1:0] next_pc,
    output logic              busy
);
    logic [1:0]        cnt_q, cnt_eff, cnt_n;
    logic [ADDR_W-1:0] tgt_q, tgt_eff, tgt_n;
    logic              pend_q, pend_eff, pend_n;
    logic [ADDR_W-1:0] ptgt_q, ptgt_eff;

    always_comb begin
        cnt_eff  = cnt_q;
        tgt_eff  = tgt_q;
        pend_eff = pend_q;
        ptgt_eff = ptgt_q;
        if (br_take) begin
            if (cnt_q == 2'd0) begin
                cnt_eff = 2'd2;
                tgt_eff = br_target;
            end else begin
                pend_eff = 1'b1;
                ptgt_eff = br_target;
            end
        end

        next_pc = pc_inc;
        cnt_n   = cnt_eff;
        tgt_n   = tgt_eff;
        pend_n  = pend_eff;
        if (cnt_eff == 2'd1) begin
            next_pc = tgt_eff;
            if (pend_eff) begin
                cnt_n  = 2'd2;
                tgt_n  = ptgt_eff;
                pend_n = 1'b0;
            end else begin
                cnt_n = 2'd0;
            end
        end else if (cnt_eff != 2'd0) begin
            cnt_n = cnt_eff - 2'd1;
        end
        busy = (cnt_q != 2'd0) | pend_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= 2'd0;
            tgt_q  <= '0;
            pend_q <= 1'b0;
            ptgt_q <= '0;
        end else if (flush) begin
            cnt_q  <= 2'd0;
            pend_q <= 1'b0;
        end else if (step) begin
            cnt_q  <= cnt_n;
            tgt_q  <= tgt_n;
            pend_q <= pend_n;
            ptgt_q <= ptgt_eff;
        end
    end

endmodule

// File: rtl/mseq_ctrl.sv
module mseq_ctrl
    import mseq_pkg::*;
#(
    parameter int ADDR_W  = 12,
    parameter int VARIANT = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [ADDR_W-1:0] start_addr_i,
    input  logic [3:0]        ctl_bits_i,
    input  logic              br_take_i,
    input  logic [ADDR_W-1:0] br_target_i,
    input  logic              brk_en_i,
    input  logic              trc_en_i,
    output logic [ADDR_W-1:0] fetch_addr_o,
    output logic              running_o,
    output logic              done_o,
    output logic              stat_brk_o,
    output logic              stat_trc_o,
    output logic              stat_mark_o,
    output logic              irq_o
);
    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(BUNDLE_BYTES);

    seq_state_e        state_q, state_d;
    logic              step;
    logic              halt;
    logic              br_busy;
    logic [ADDR_W-1:0] pc_q;
    logic [ADDR_W-1:0] pc_next;
    flag_hits_t        hits;

    assign step = (state_q == ST_RUN) && !start_i;

    mseq_flag_dec #(.VARIANT(VARIANT)) u_dec (
        .active   (step),
        .ctl_bits (ctl_bits_i),
        .brk_en   (brk_en_i),
        .trc_en   (trc_en_i),
        .hits     (hits)
    );

    mseq_end_timer u_end (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (start_i),
        .step      (step),
        .load_two  (hits.end_hit),
        .force_one (hits.stop_now),
        .expire    (halt)
    );

    mseq_branch #(.ADDR_W(ADDR_W)) u_br (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (start_i | halt),
        .step      (step),
        .br_take   (br_take_i),
        .br_target (br_target_i),
        .pc_inc    (pc_q + STEP),
        .next_pc   (pc_next),
        .busy      (br_busy)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start_i) state_d = ST_RUN;
            ST_RUN: begin
                if (start_i)   state_d = ST_RUN;
                else if (halt) state_d = ST_IDLE;
                else           state_d = ST_RUN;
            end
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pc_q        <= '0;
            stat_brk_o  <= 1'b0;
            stat_trc_o  <= 1'b0;
            stat_mark_o <= 1'b0;
            irq_o       <= 1'b0;
            done_o      <= 1'b0;
        end else begin
            irq_o  <= hits.brk_hit | hits.trc_hit;
            done_o <= halt;
            if (start_i) begin
                pc_q        <= start_addr_i;
                stat_brk_o  <= 1'b0;
                stat_trc_o  <= 1'b0;
                stat_mark_o <= 1'b0;
            end else if (step) begin
                pc_q <= pc_next;
                if (hits.brk_hit)  stat_brk_o  <= 1'b1;
                if (hits.trc_hit)  stat_trc_o  <= 1'b1;
                if (hits.mark_hit) stat_mark_o <= 1'b1;
            end
        end
    end

    assign fetch_addr_o = pc_q;
    assign running_o    = (state_q == ST_RUN);

endmodule

// File: rtl/mseq_ctrl_chk.sv
module mseq_ctrl_chk #(
    parameter int ADDR_W  = 12,
    parameter int VARIANT = 0
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start_i,
    input logic [ADDR_W-1:0] start_addr_i,
    input logic              br_take_i,
    input logic              br_busy,
    input logic [ADDR_W-1:0] fetch_addr_o,
    input logic              running_o,
    input logic              done_o,
    input logic              stat_brk_o,
    input logic              stat_trc_o,
    input logic              stat_mark_o,
    input logic              irq_o
);
    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(8);

    assert_start_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> running_o && (fetch_addr_o == $past(start_addr_i)));

    assert_linear_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        running_o && !start_i && !br_busy && !br_take_i
        |=> fetch_addr_o == $past(fetch_addr_o) + STEP);

    assert_done_on_fall_R4: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !running_o && $past(running_o));

    assert_idle_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !running_o && !start_i |=> $stable(fetch_addr_o) && !irq_o);

    assert_brk_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        stat_brk_o && !start_i |=> stat_brk_o);

    assert_irq_from_run_R6: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> $past(running_o));

    assert_trc_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        stat_trc_o && !start_i |=> stat_trc_o);

    assert_stop_halts_R8: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (VARIANT == 0) || (!running_o && done_o));

    assert_mark_variant_R9: assert property (@(posedge clk) disable iff (!rst_n)
        stat_mark_o |-> (VARIANT == 0));

endmodule

bind mseq_ctrl mseq_ctrl_chk #(.ADDR_W(ADDR_W), .VARIANT(VARIANT)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start_i),
    .start_addr_i (start_addr_i),
    .br_take_i    (br_take_i),
    .br_busy      (br_busy),
    .fetch_addr_o (fetch_addr_o),
    .running_o    (running_o),
    .done_o       (done_o),
    .stat_brk_o   (stat_brk_o),
    .stat_trc_o   (stat_trc_o),
    .stat_mark_o  (stat_mark_o),
    .irq_o        (irq_o)
);

// File: tb/test_mseq_ctrl.sv
module test_mseq_ctrl;
    localparam int AW = 9;
    localparam int NB = 64;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    logic          start = 1'b0;
    logic [AW-1:0] start_addr = '0;
    logic          brk_en = 1'b0;
    logic          trc_en = 1'b0;

    logic [3:0]    hi_tab [NB];
    logic          br_tab [NB];
    logic [AW-1:0] tg_tab [NB];

    logic [AW-1:0] fa  [2];
    logic [3:0]    fl  [2];
    logic          bt  [2];
    logic [AW-1:0] btg [2];
    logic run [2], dn [2], sb [2], st [2], sm [2], irq [2];

    assign fl[0]  = hi_tab[fa[0][AW-1:3]];
    assign bt[0]  = br_tab[fa[0][AW-1:3]];
    assign btg[0] = tg_tab[fa[0][AW-1:3]];
    assign fl[1]  = hi_tab[fa[1][AW-1:3]];
    assign bt[1]  = br_tab[fa[1][AW-1:3]];
    assign btg[1] = tg_tab[fa[1][AW-1:3]];

    mseq_ctrl #(.ADDR_W(AW), .VARIANT(0)) i_mseq_ctrl (
        .clk(clk), .rst_n(rst_n), .start_i(start), .start_addr_i(start_addr),
        .ctl_bits_i(fl[0]), .br_take_i(bt[0]), .br_target_i(btg[0]),
        .brk_en_i(brk_en), .trc_en_i(trc_en), .fetch_addr_o(fa[0]),
        .running_o(run[0]), .done_o(dn[0]), .stat_brk_o(sb[0]),
        .stat_trc_o(st[0]), .stat_mark_o(sm[0]), .irq_o(irq[0]));

    mseq_ctrl #(.ADDR_W(AW), .VARIANT(1)) i_mseq_ctrl_v1 (
        .clk(clk), .rst_n(rst_n), .start_i(start), .start_addr_i(start_addr),
        .ctl_bits_i(fl[1]), .br_take_i(bt[1]), .br_target_i(btg[1]),
        .brk_en_i(brk_en), .trc_en_i(trc_en), .fetch_addr_o(fa[1]),
        .running_o(run[1]), .done_o(dn[1]), .stat_brk_o(sb[1]),
        .stat_trc_o(st[1]), .stat_mark_o(sm[1]), .irq_o(irq[1]));

    typedef struct packed {
        logic [AW-1:0] pc;
        logic          run;
        logic [1:0]    ec;
        logic [1:0]    bc;
        logic [AW-1:0] tg;
        logic [AW-1:0] ptg;
        logic          pv;
        logic          sb, st, sm, irq, done;
    } mst_t;

    mst_t m [2];
    int   nchk = 0;
    int   nerr = 0;
    bit   fin = 1'b0;

    // expected next state of one unit, written from R2..R11
    function automatic mst_t mstep(mst_t s, int v, logic go, logic [AW-1:0] ga,
                                   logic be, logic te);
        mst_t          n;
        logic [3:0]    f;
        logic          fb, ft;
        logic [1:0]    ec;
        logic [AW-1:0] npc;
        int            idx;
        n = s;
        n.irq  = 1'b0;
        n.done = 1'b0;
        if (go) begin
            n.pc = ga; n.run = 1'b1; n.ec = 2'd0; n.bc = 2'd0; n.pv = 1'b0;
            n.sb = 1'b0; n.st = 1'b0; n.sm = 1'b0;
        end else if (s.run) begin
            idx = int'(s.pc[AW-1:3]);
            f   = hi_tab[idx];
            fb  = f[1] & be;
            ft  = f[0] & te;
            n.sb  = s.sb | fb;
            n.st  = s.st | ft;
            n.irq = fb | ft;
            if (v == 0 && f[2]) n.sm = 1'b1;
            ec = s.ec;
            if (f[3]) ec = 2'd2;
            if (v == 1 && (fb | ft)) ec = 2'd1;
            npc = s.pc + AW'(8);
            if (br_tab[idx]) begin
                if (n.bc == 2'd0) begin n.bc = 2'd2; n.tg = tg_tab[idx]; end
                else begin n.pv = 1'b1; n.ptg = tg_tab[idx]; end
            end
            if (n.bc == 2'd1) begin
                npc = n.tg;
                if (n.pv) begin n.bc = 2'd2; n.tg = n.ptg; n.pv = 1'b0; end
                else n.bc = 2'd0;
            end else if (n.bc != 2'd0) begin
                n.bc = n.bc - 2'd1;
            end
            n.pc = npc;
            if (ec == 2'd1) begin
                n.run = 1'b0; n.done = 1'b1; n.ec = 2'd0; n.bc = 2'd0; n.pv = 1'b0;
            end else begin
                n.ec = (ec == 2'd0) ? 2'd0 : ec - 2'd1;
            end
        end
        return n;
    endfunction

    task automatic cmp(int v, string req);
        logic [AW+5:0] a, e;
        a = {fa[v], run[v], sb[v], st[v], sm[v], irq[v], dn[v]};
        e = {m[v].pc, m[v].run, m[v].sb, m[v].st, m[v].sm, m[v].irq, m[v].done};
        nchk++;
        if (a !== e) begin
            nerr++;
            $display("FAIL %s unit%0d {pc,run,brk,trc,mark,irq,done} actual %h expected %h",
                     req, v, a, e);
        end
    endtask

    task automatic want(string req, logic [31:0] act, logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    // one clock: apply stimulus, advance the model, check after the edge
    task automatic tick(logic go, logic [AW-1:0] ga, string req);
        start      = go;
        start_addr = ga;
        for (int v = 0; v < 2; v++) m[v] = mstep(m[v], v, go, ga, brk_en, trc_en);
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        for (int v = 0; v < 2; v++) cmp(v, req);
    endtask

    task automatic clear_tabs();
        for (int i = 0; i < NB; i++) begin
            hi_tab[i] = 4'd0; br_tab[i] = 1'b0; tg_tab[i] = '0;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!fin) begin
            nerr++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", nchk, nerr);
            $finish;
        end
    end

    initial begin
        int x;
        x = $urandom(32'd1337);
        clear_tabs();
        m[0] = '0;
        m[1] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        for (int v = 0; v < 2; v++) cmp(v, "R1");
        want("R1 fetch", 32'(fa[0]), 32'h0);

        // R2 R3 R4 R5: end flag at 0x50, break at 0x60 never executed
        hi_tab[10] = 4'b1000;
        hi_tab[12] = 4'b0010;
        brk_en = 1'b1;
        trc_en = 1'b0;
        tick(1'b1, 9'h040, "R2");
        want("R2 addr", 32'(fa[0]), 32'h40);
        want("R2 run", 32'(run[1]), 32'h1);
        tick(1'b0, '0, "R3");
        want("R3 addr", 32'(fa[0]), 32'h48);
        tick(1'b0, '0, "R3");
        tick(1'b0, '0, "R4");
        want("R4 slot runs", {fa[0], run[0]}, {9'h058, 1'b1});
        tick(1'b0, '0, "R4");
        want("R4 halt", {fa[1], run[1], dn[1]}, {9'h060, 1'b0, 1'b1});
        tick(1'b0, '0, "R5");
        want("R5 idle", {fa[0], irq[0], sb[0], dn[0]}, {9'h060, 3'b000});
        tick(1'b0, '0, "R5");

        // R6 R7 R8 R9
        clear_tabs();
        hi_tab[17] = 4'b0010;
        hi_tab[18] = 4'b0001;
        hi_tab[19] = 4'b0001;
        hi_tab[20] = 4'b0100;
        hi_tab[21] = 4'b1000;
        tick(1'b1, 9'h080, "R2");
        tick(1'b0, '0, "R6");
        tick(1'b0, '0, "R6");
        want("R6 brk", {sb[0], irq[0], run[0]}, 3'b111);
        want("R8 stop", {sb[1], irq[1], run[1], dn[1]}, 4'b1101);
        tick(1'b0, '0, "R7");
        want("R7 gated", {st[0], irq[0]}, 2'b00);
        trc_en = 1'b1;
        tick(1'b0, '0, "R7");
        want("R7 trace", {st[0], irq[0]}, 2'b11);
        tick(1'b0, '0, "R9");
        want("R9 mark", 32'(sm[0]), 32'h1);
        tick(1'b0, '0, "R4");
        tick(1'b0, '0, "R4");
        tick(1'b1, 9'h0A0, "R2");
        want("R2 clear", 32'(sm[0]), 32'h0);
        tick(1'b0, '0, "R9");
        want("R9 ignore", {sm[0], sm[1]}, 2'b10);
        tick(1'b0, '0, "R4");
        tick(1'b0, '0, "R4");

        // R10: branch at 0x108 to 0x180
        clear_tabs();
        br_tab[33] = 1'b1; tg_tab[33] = 9'h180;
        hi_tab[49] = 4'b1000;
        tick(1'b1, 9'h100, "R2");
        tick(1'b0, '0, "R10");
        tick(1'b0, '0, "R10");
        want("R10 slot", 32'(fa[0]), 32'h110);
        tick(1'b0, '0, "R10");
        want("R10 target", 32'(fa[1]), 32'h180);
        tick(1'b0, '0, "R10");
        want("R10 after", 32'(fa[0]), 32'h188);
        tick(1'b0, '0, "R4");
        tick(1'b0, '0, "R4");

        // R11: branch in delay slot
        clear_tabs();
        br_tab[40] = 1'b1; tg_tab[40] = 9'h1C0;
        br_tab[41] = 1'b1; tg_tab[41] = 9'h020;
        hi_tab[5]  = 4'b1000;
        tick(1'b1, 9'h140, "R2");
        tick(1'b0, '0, "R11");
        tick(1'b0, '0, "R11");
        want("R11 first", 32'(fa[0]), 32'h1C0);
        tick(1'b0, '0, "R11");
        want("R11 t1+8", 32'(fa[0]), 32'h1C8);
        tick(1'b0, '0, "R11");
        want("R11 pending", 32'(fa[1]), 32'h020);
        for (int k = 0; k < 3; k++) tick(1'b0, '0, "R4");

        // random programs
        for (int r = 0; r < 60; r++) begin
            for (int i = 0; i < NB; i++) begin
                x = $urandom;
                hi_tab[i] = {x[3:0] == 4'd0, x[7:5] == 3'd0, x[11:8] == 4'd0, x[15:12] == 4'd0};
                br_tab[i] = (x[18:16] == 3'd0);
                tg_tab[i] = {x[26:21], 3'b000};
            end
            x = $urandom;
            brk_en = x[0];
            trc_en = x[1];
            tick(1'b1, {x[10:5], 3'b000}, "R2");
            for (int k = 0; k < 80; k++) begin
                x = $urandom;
                if (x[5:0] == 6'd0) tick(1'b1, {x[15:10], 3'b000}, "R2 restart");
                else tick(1'b0, '0, "R3 R4 R6 R7 R8 R9 R10 R11");
                if (!m[0].run && !m[1].run) break;
            end
            tick(1'b0, '0, "R5");
        end

        fin = 1'b1;
        $display("CHECKS %0d ERRORS %0d", nchk, nerr);
        $finish;
    end

endmodule